// File: doc/BRIEF.md
# Bridge Control Register File

This block is the control and status register bank of a host bridge. It holds
28 words of 32 bits. A simple CPU bus reaches each word at a byte offset between
0x00 and 0x6C. Most words are plain storage that the surrounding bridge logic
uses for mapping, GPIO, mailbox and timing settings, and each comes out of reset
with a fixed value.

Two words are write-only aliases of an interrupt-enable word:

- The set alias ORs the written ones into the enable word.
- The clear alias removes the written ones from the enable word.

The enable word and the interrupt-status word cannot be written.

A write to the general-configuration word that raises bit 2 from 0 to 1 emits a
one-cycle system reset request. That write also stores its value. The request
leaves the bank itself untouched.

Top module: `bridge_ctl_regs`

## Requirements
- R1: The word index is the byte offset shifted right by two; offset bits [1:0] are ignored. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled high.
- R2: A write to offset 0x30 stores the written value at 0x30 and ORs it into the enable word at 0x38.
- R3: A write to offset 0x34 stores the written value at 0x34 and clears in the enable word at 0x38 every bit written as one.
- R4: Writes to 0x38 and to 0x3C change nothing. The enable word changes only through 0x30 and 0x34. The status word at 0x3C always reads zero.
- R5: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 drives `reset_req` high for exactly the one cycle after the write edge. The written value is stored.
- R6: No request is issued when the stored bit 2 is already 1 or when bit 2 is written as 0. A request leaves all register contents unchanged.
- R7: Writes to offsets 0x70 to 0x7F are ignored, and reads from those offsets return zero.
- R8: After reset the bank holds these values: 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000.
- R9: Every other word resets to zero. Each writable word other than the enable word reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A write is visible in the bank after its own clock edge, so a read issued in the
next cycle already sees it. The read data then appears one edge after that read
is sampled. The reset request comes from a register and is high only in the
cycle after the write edge.

The bench drives each transaction on a falling edge. It compares `bus_rdata` and
`reset_req` on the following falling edge, which is exactly one rising edge
later. It checks one more falling edge to confirm that the request has dropped.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DATA_W    = 32;
  localparam int IDX_GEN   = 1;   // general configuration word
  localparam int IDX_ENSET = 12;  // enable set alias
  localparam int IDX_ENCLR = 13;  // enable clear alias
  localparam int IDX_EN    = 14;  // enable word, read-only
  localparam int IDX_STS   = 15;  // status word, read-only

  function automatic logic [DATA_W-1:0] rst_value(int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic plain_writable(int idx, int nregs);
    return (idx < nregs) && (idx != IDX_EN) && (idx != IDX_STS);
  endfunction

  function automatic logic [DATA_W-1:0] en_update(logic [DATA_W-1:0] cur,
                                                  logic do_set, logic do_clr,
                                                  logic [DATA_W-1:0] data);
    logic [DATA_W-1:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | data;
    if (do_clr) nxt = nxt & ~data;
    return nxt;
  endfunction

  function automatic logic bit_rise(logic old_b, logic new_b);
    return !old_b && new_b;
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode #(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 28,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];
  assign idx = addr[ADDR_W-1:2];
  assign hit = (32'(idx) < NUM_REGS);
endmodule

// File: rtl/bcr_bank.sv
module bcr_bank
  import bcr_pkg::*;
#(
  parameter int NUM_REGS = 28,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  logic set_hit, clr_hit;
  assign set_hit = wr_en && (wr_idx == IDX_W'(IDX_ENSET));
  assign clr_hit = wr_en && (wr_idx == IDX_W'(IDX_ENCLR));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_EN) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_o[i] <= rst_value(i);
        else        regs_o[i] <= en_update(regs_o[i], set_hit, clr_hit, wdata);
      end
    end else if (plain_writable(i, NUM_REGS)) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               regs_o[i] <= rst_value(i);
        else if (wr_en && wr_idx == IDX_W'(i))    regs_o[i] <= wdata;
      end
    end else begin : g_ro
      assign regs_o[i] = rst_value(i);
    end
  end
endmodule

// File: rtl/bcr_rstreq.sv
module bcr_rstreq
  import bcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req_o
);
  logic req_d;
  assign req_d = gen_wr && bit_rise(old_bit, new_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_d;
  end
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 28,
  parameter int RST_BIT  = 2,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              wr_hit;
  logic              gen_wr;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] en_q, gen_q, sts_q;

  bcr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(bus_addr), .idx(idx), .hit(hit)
  );

  assign wr_hit = bus_wr && hit;
  assign gen_wr = wr_hit && (idx == IDX_W'(IDX_GEN));

  bcr_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wr_idx(idx),
    .wdata(bus_wdata), .regs_o(regs)
  );

  assign en_q  = regs[IDX_EN];
  assign gen_q = regs[IDX_GEN];
  assign sts_q = regs[IDX_STS];

  bcr_rstreq u_req (
    .clk(clk), .rst_n(rst_n), .gen_wr(gen_wr),
    .old_bit(gen_q[RST_BIT]), .new_bit(bus_wdata[RST_BIT]),
    .req_o(reset_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? regs[idx] : '0;
  end
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 28,
  parameter int RST_BIT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              reset_req,
  input logic [31:0]       en_q,
  input logic [31:0]       gen_q,
  input logic [31:0]       sts_q
);
  logic [ADDR_W-3:0] cidx;
  logic wr_set, wr_clr, wr_gen, rd_oob;
  assign cidx   = bus_addr[ADDR_W-1:2];
  assign wr_set = bus_wr && 32'(cidx) == 12;
  assign wr_clr = bus_wr && 32'(cidx) == 13;
  assign wr_gen = bus_wr && 32'(cidx) == 1;
  assign rd_oob = bus_rd && 32'(cidx) >= NUM_REGS;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata)) == 32'h0));

  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q));

  p_sts_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (sts_q == 32'h0));

  p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_gen && bus_wdata[RST_BIT] && !gen_q[RST_BIT]));

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |=> (bus_rdata == 32'h0));
endmodule

bind bridge_ctl_regs bcr_checker #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RST_BIT(RST_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .reset_req(reset_req), .en_q(en_q), .gen_q(gen_q), .sts_q(sts_q)
);

// File: tb/tb_bridge_ctl_regs.sv
`timescale 1ns/1ps
module tb_bridge_ctl_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] m [28];

  always #10 clk = ~clk;

  bridge_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  function automatic logic [31:0] init_val(int i);
    case (i)
      0: return 32'h00000C40;   1: return 32'h00001384;
      2: return 32'h2BFF8010;   3: return 32'h255E0091;
      4: return 32'h00006140;   7: return 32'h000001FF;
      8: return 32'h000001FF;  26: return 32'h00000008;
      27: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (i >= 28) return "R7";
    if (i == 12 || i == 14) return "R2";
    if (i == 13) return "R3";
    if (i == 15) return "R4";
    if (i == 1) return "R5";
    return "R9";
  endfunction

  function automatic bit model_write(int a, logic [31:0] d);
    int i = a / 4;
    bit p = 0;
    if (i >= 28) return 0;
    case (i)
      14, 15: ;
      12: begin m[12] = d; m[14] = m[14] | d; end
      13: begin m[13] = d; m[14] = m[14] & ~d; end
      1:  begin p = !m[1][2] && d[2]; m[1] = d; end
      default: m[i] = d;
    endcase
    return p;
  endfunction

  function automatic logic [31:0] model_read(int a);
    return (a / 4 < 28) ? m[a / 4] : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bit p;
    p = model_write(a, d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    check(p ? "R5" : "R6", {31'h0, reset_req}, {31'h0, p});
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    bus_rd = 1; bus_addr = 7'(a);
    @(negedge clk);
    bus_rd = 0;
    check(req, bus_rdata, model_read(a));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 28; i++) m[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R5", {31'h0, reset_req}, 32'h0);
    // R8 / R9 reset state, R7 reads beyond the bank
    for (int i = 0; i < 32; i++) rd(i * 4, (init_val(i) != 0) ? "R8" : tag_of(i));
    // R2 set alias
    wr(32'h30, 32'h0000_00F0); rd(32'h38, "R2"); rd(32'h30, "R2");
    // R3 clear alias
    wr(32'h34, 32'h0000_0030); rd(32'h38, "R3"); rd(32'h34, "R3");
    // R4 read-only words
    wr(32'h38, 32'hFFFF_FFFF); rd(32'h38, "R4");
    wr(32'h3C, 32'hFFFF_FFFF); rd(32'h3C, "R4");
    // R5 / R6 reset request
    wr(32'h04, 32'h0000_0004);               // stored bit already 1: no pulse
    wr(32'h04, 32'h0000_0000); rd(32'h04, "R6");
    wr(32'h04, 32'h0000_0004);               // rising: pulse
    @(negedge clk);
    check("R5", {31'h0, reset_req}, 32'h0);  // single cycle
    rd(32'h04, "R5"); rd(32'h6C, "R6"); rd(32'h38, "R6");
    // R1 low address bits ignored
    wr(32'h43, 32'hA5A5_0001); rd(32'h40, "R1"); rd(32'h42, "R1");
    // R7 beyond the bank
    wr(32'h70, 32'hDEAD_BEEF); rd(32'h70, "R7"); rd(32'h7C, "R7");
    rd(32'h6C, "R7");
    // random mix
    for (int k = 0; k < 600; k++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom % 128);
      if ($urandom % 4 == 0) a = 4 + int'($urandom % 2) * 44; // 0x04 or 0x30
      d = $urandom;
      if ($urandom % 2 == 0) wr(a, d);
      else rd(a, tag_of(a / 4));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule